// File: doc/BRIEF.md
# Reset Source Qualifier and Cause Register

This block gathers the reset requests of a chip (external pin, watchdog, temperature sensor, core lockup, software system request, debug-port reset and a failure of the secure always-on domain), filters them through controls that software programs, and forwards one combined reset request together with its class (warm or cold) to a downstream reset sequencer. The sequencing itself, its timing and any pin drivers live elsewhere.

Every source that fires leaves a flag in a cause register, so that boot software can learn why the chip was reset. The block's own synchronous reset stands for power-on: it clears every flag and then marks only the power-on flag. Software reaches the block through a minimal register port: one write strobe, one select bit choosing between the control word (select 0) and the cause word (select 1), a write-data bus and a combinational read-data bus.

The watchdog and temperature-sensor masks are guarded by multi-bit key codes, so a single corrupted bit cannot silence a reset source. The cause flags clear on a write of one, while a software-owned warm-boot marker in the same word follows plain writes.

Top module: `rst_cause_qual`

## Requirements
- R1: While rst_n is low at a clock edge the block returns to its power-on state: cause word reads 0x001 (only bit 0, power-on, set; warm-boot bit 8 clear), control word reads 0x22A, rst_req_o and rst_cold_o are 0.
- R2: Control bits [3:0] carry the watchdog key: writing 0xA unmasks the watchdog, 0x5 masks it; the field reads back 0xA when unmasked and 0x5 when masked.
- R3: Control bits [7:4] carry the temperature-sensor key: 0x2 unmasks, 0x5 masks; the field reads back 0x2 or 0x5 accordingly.
- R4: A control write whose key field holds any other value leaves that source's mask state unchanged.
- R5: Cause word bits are 1 pin, 2 watchdog, 3 temperature, 4 lockup, 5 software request, 6 debug-port reset, 7 secure-domain failure; a request seen at a clock edge sets its flag at that edge, and requests arriving together set all their flags together. Watchdog and temperature flags are set even while masked.
- R6: rst_req_o rises one clock after any qualified request and is 0 one clock after a cycle with none; a masked watchdog or temperature request is not qualified.
- R7: Control bit 8 enables lockup: when clear, a lockup request neither sets its flag nor produces a reset request.
- R8: While the watchdog (or temperature) source is masked, its cause flag cannot be cleared by software; only rst_n clears it.
- R9: Writing the cause word clears each flag 0..7 whose write-data bit is 1 (subject to R8); a source request in the same cycle wins and leaves its flag set.
- R10: Bit 8 of the cause word is the warm-boot marker: every cause-word write loads it from write-data bit 8, and a write with data bits 7:0 zero leaves all flags untouched.
- R11: rst_cold_o (registered with rst_req_o) is 1 when the qualified set includes the pin or secure-domain failure, or when control bit 9 (warm enable) is clear; otherwise a request is warm (rst_cold_o 0). A secure-domain failure always requests a cold reset whatever the masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 the cause word |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the selected word |
| req_pin | input | 1 | External pin reset request |
| req_wdog | input | 1 | Watchdog timeout request |
| req_temp | input | 1 | Temperature-sensor reset request |
| req_lockup | input | 1 | Core lockup indication |
| req_sw | input | 1 | Software system reset request |
| req_jtag | input | 1 | Debug-port generated reset request |
| req_secfail | input | 1 | Secure always-on domain failure |
| rst_req_o | output | 1 | Combined reset request to the sequencer |
| rst_cold_o | output | 1 | 1 = cold class, 0 = warm class |

## Verification
The assertions assume that request inputs and register writes are synchronous to clk and held stable around each edge, and that the block's own rst_n is the only way a power-on event reaches it. The stimulus keeps to this by changing every input on the falling edge, sweeping all sixteen mask and enable combinations against all 128 request patterns, and all sixteen key values for both key fields from both mask states.

// File: rtl/rcq_pkg.sv
// Package: shared widths, key codes and bit positions of the reset cause block.
// Assumes a single clock domain; all positions below are visible to software.
package rcq_pkg;
    localparam int NSRC      = 8;   // cause flags, bit 0 is power-on
    localparam int KEY_W     = 4;
    localparam int SRC_POR   = 0;
    localparam int SRC_PIN   = 1;
    localparam int SRC_WDOG  = 2;
    localparam int SRC_TEMP  = 3;
    localparam int SRC_LOCK  = 4;
    localparam int SRC_SW    = 5;
    localparam int SRC_JTAG  = 6;
    localparam int SRC_SEC   = 7;
    localparam int WBI_BIT   = NSRC;          // warm-boot marker in cause word
    localparam int WDOG_LSB  = 0;             // control word fields
    localparam int TEMP_LSB  = KEY_W;
    localparam int LOCK_BIT  = 2 * KEY_W;
    localparam int WARM_BIT  = 2 * KEY_W + 1;
    localparam logic [KEY_W-1:0] WDOG_OPEN = 4'hA;
    localparam logic [KEY_W-1:0] WDOG_SHUT = 4'h5;
    localparam logic [KEY_W-1:0] TEMP_OPEN = 4'h2;
    localparam logic [KEY_W-1:0] TEMP_SHUT = 4'h5;
    localparam logic [NSRC-1:0]  COLD_SRCS = (NSRC'(1) << SRC_PIN) | (NSRC'(1) << SRC_SEC);
endpackage

// File: rtl/rcq_key_mask.sv
// Keyed mask bit: only the exact shut code masks and the exact open code unmasks.
// Assumes wr_en is a one-cycle write of the control word; other codes are ignored.
module rcq_key_mask #(
    parameter int               W         = 4,
    parameter logic [W-1:0]     OPEN_CODE = 4'hA,
    parameter logic [W-1:0]     SHUT_CODE = 4'h5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] key,
    output logic         masked,
    output logic [W-1:0] code_o
);
    // Mask state: unmasked after reset, moves only on a recognised key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            masked <= 1'b0;
        else if (wr_en && key == SHUT_CODE)
            masked <= 1'b1;
        else if (wr_en && key == OPEN_CODE)
            masked <= 1'b0;
    end

    // Readback shows the code that selects the current state.
    assign code_o = masked ? SHUT_CODE : OPEN_CODE;
endmodule

// File: rtl/rcq_cause_flags.sv
// Cause flag register: set by source events, write-one-to-clear by software,
// with per-bit hold that blocks clearing; plus a plain read/write marker bit.
// Assumes set_vec is already gated by any enable; set has priority over clear.
module rcq_cause_flags #(
    parameter int N       = 8,
    parameter int POR_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] hold_vec,
    input  logic         mark_val,
    output logic [N-1:0] flags,
    output logic         mark
);
    logic [N-1:0] clr_eff;

    // Effective clear: requested bits minus those currently held.
    always_comb clr_eff = clr_wr ? (clr_vec & ~hold_vec) : '0;

    // Flag update: power-on leaves only the power-on flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= N'(1) << POR_BIT;
        else
            flags <= (flags & ~clr_eff) | set_vec;
    end

    // Marker bit: loaded by every cause-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mark <= 1'b0;
        else if (clr_wr)
            mark <= mark_val;
    end
endmodule

// File: rtl/rcq_req_merge.sv
// Combines qualified requests into one registered request and its class.
// Assumes qual holds only sources that may reset the chip in this cycle.
module rcq_req_merge #(
    parameter int              N        = 8,
    parameter logic [N-1:0]    COLD_SET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] qual,
    input  logic         warm_en,
    output logic         req_o,
    output logic         cold_o
);
    logic any_req;
    logic force_cold;

    // Class decision: cold if a cold-only source fires or warm is disabled.
    always_comb begin
        any_req    = |qual;
        force_cold = (|(qual & COLD_SET)) || !warm_en;
    end

    // Output register towards the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            cold_o <= 1'b0;
        end else begin
            req_o  <= any_req;
            cold_o <= any_req && force_cold;
        end
    end
endmodule

// File: rtl/rst_cause_qual.sv
// Reset source qualifier: keyed masks, lockup enable, cause flags and the
// combined warm/cold reset request. rst_n acts as the power-on reset.
// Assumes all request inputs are synchronous to clk.
module rst_cause_qual
    import rcq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_pin,
    input  logic              req_wdog,
    input  logic              req_temp,
    input  logic              req_lockup,
    input  logic              req_sw,
    input  logic              req_jtag,
    input  logic              req_secfail,
    output logic              rst_req_o,
    output logic              rst_cold_o
);
    localparam int USED_W = WARM_BIT + 1;

    logic             ctrl_wr, stat_wr;
    logic             wdog_masked, temp_masked;
    logic [KEY_W-1:0] wdog_code, temp_code;
    logic             lock_en, warm_en;
    logic [NSRC-1:0]  raw, set_vec, qual, hold_vec, flags;
    logic             wbi;
    logic             unused_wdata;

    assign ctrl_wr      = reg_wr && !reg_sel;
    assign stat_wr      = reg_wr && reg_sel;
    assign unused_wdata = ^reg_wdata[DATA_W-1:USED_W];

    rcq_key_mask #(.W(KEY_W), .OPEN_CODE(WDOG_OPEN), .SHUT_CODE(WDOG_SHUT)) u_wdog_key (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
        .key(reg_wdata[WDOG_LSB +: KEY_W]), .masked(wdog_masked), .code_o(wdog_code)
    );

    rcq_key_mask #(.W(KEY_W), .OPEN_CODE(TEMP_OPEN), .SHUT_CODE(TEMP_SHUT)) u_temp_key (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
        .key(reg_wdata[TEMP_LSB +: KEY_W]), .masked(temp_masked), .code_o(temp_code)
    );

    // Plain control bits: lockup enable (off) and warm enable (on) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_en <= 1'b0;
            warm_en <= 1'b1;
        end else if (ctrl_wr) begin
            lock_en <= reg_wdata[LOCK_BIT];
            warm_en <= reg_wdata[WARM_BIT];
        end
    end

    // Source qualification: flag set vector, reset-eligible vector, clear hold.
    always_comb begin
        raw = '0;
        raw[SRC_PIN]  = req_pin;
        raw[SRC_WDOG] = req_wdog;
        raw[SRC_TEMP] = req_temp;
        raw[SRC_LOCK] = req_lockup;
        raw[SRC_SW]   = req_sw;
        raw[SRC_JTAG] = req_jtag;
        raw[SRC_SEC]  = req_secfail;
        set_vec            = raw;
        set_vec[SRC_LOCK]  = raw[SRC_LOCK] && lock_en;
        qual               = set_vec;
        qual[SRC_WDOG]     = raw[SRC_WDOG] && !wdog_masked;
        qual[SRC_TEMP]     = raw[SRC_TEMP] && !temp_masked;
        hold_vec           = '0;
        hold_vec[SRC_WDOG] = wdog_masked;
        hold_vec[SRC_TEMP] = temp_masked;
    end

    rcq_cause_flags #(.N(NSRC), .POR_BIT(SRC_POR)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_wr(stat_wr), .clr_vec(reg_wdata[NSRC-1:0]), .hold_vec(hold_vec),
        .mark_val(reg_wdata[WBI_BIT]), .flags(flags), .mark(wbi)
    );

    rcq_req_merge #(.N(NSRC), .COLD_SET(COLD_SRCS)) u_merge (
        .clk(clk), .rst_n(rst_n), .qual(qual), .warm_en(warm_en),
        .req_o(rst_req_o), .cold_o(rst_cold_o)
    );

    // Read mux of the selected word.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[NSRC-1:0] = flags;
            reg_rdata[WBI_BIT]  = wbi;
        end else begin
            reg_rdata[WDOG_LSB +: KEY_W] = wdog_code;
            reg_rdata[TEMP_LSB +: KEY_W] = temp_code;
            reg_rdata[LOCK_BIT]          = lock_en;
            reg_rdata[WARM_BIT]          = warm_en;
        end
    end
endmodule

// File: rtl/rcq_checker.sv
// Checker: temporal properties of the reset cause block, bound to the top.
// Assumes inputs change away from the rising edge.
module rcq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] raw,
    input logic [7:0] flags,
    input logic       wbi,
    input logic       wdog_masked,
    input logic       lock_en,
    input logic       ctrl_wr,
    input logic [3:0] wkey,
    input logic       rst_req_o,
    input logic       rst_cold_o
);
    // R1: power-on state one cycle after a reset edge
    p_por_state_r1: assert property (@(posedge clk)
        !rst_n |=> (flags == 8'h01 && !wbi && !rst_req_o && !rst_cold_o));

    // R4: unrecognised watchdog key keeps the mask state
    p_badkey_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wkey != 4'hA && wkey != 4'h5) |=> $stable(wdog_masked));

    // R5: debug-port request leaves its flag set
    p_jtag_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        raw[6] |=> flags[6]);

    // R7: disabled lockup neither flags nor requests
    p_lock_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_en && raw[4] && !flags[4] && raw[7:5] == 3'b000 && raw[3:0] == 4'b0000)
        |=> (!flags[4] && !rst_req_o));

    // R8: masked watchdog flag cannot be cleared
    p_wdog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_masked && flags[2]) |=> flags[2]);

    // R11: secure-domain failure always yields a cold request
    p_secfail_cold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        raw[7] |=> (rst_req_o && rst_cold_o));
endmodule

bind rst_cause_qual rcq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .raw(raw), .flags(flags), .wbi(wbi),
    .wdog_masked(wdog_masked), .lock_en(lock_en), .ctrl_wr(ctrl_wr),
    .wkey(reg_wdata[3:0]), .rst_req_o(rst_req_o), .rst_cold_o(rst_cold_o)
);

// File: tb/tb_rst_cause_qual.sv
module tb_rst_cause_qual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_pin = 0, req_wdog = 0, req_temp = 0, req_lockup = 0;
    logic        req_sw = 0, req_jtag = 0, req_secfail = 0;
    logic        rst_req_o, rst_cold_o;

    int errors = 0, checks = 0;

    // model state
    logic       m_wm = 0, m_tm = 0, m_len = 0, m_wen = 1, m_wbi = 0;
    logic [7:0] m_flags = 8'h01;
    logic       m_req = 0, m_cold = 0;

    always #4 clk = ~clk;

    rst_cause_qual dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_pin(req_pin), .req_wdog(req_wdog), .req_temp(req_temp),
        .req_lockup(req_lockup), .req_sw(req_sw), .req_jtag(req_jtag),
        .req_secfail(req_secfail), .rst_req_o(rst_req_o), .rst_cold_o(rst_cold_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        return {22'd0, m_wen, m_len, (m_tm ? 4'h5 : 4'h2), (m_wm ? 4'h5 : 4'hA)};
    endfunction

    // One clock: drive at falling edge, update model at the rising edge,
    // return at the next falling edge with inputs still applied.
    // rq bits: 0 pin,1 wdog,2 temp,3 lockup,4 sw,5 jtag,6 secfail
    task automatic cyc(input logic wr, input logic sel, input logic [31:0] wd, input logic [6:0] rq);
        logic [7:0] setv, qualv, holdv;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        {req_secfail, req_jtag, req_sw, req_lockup, req_temp, req_wdog, req_pin} = rq;
        @(posedge clk);
        setv  = {rq[6], rq[5], rq[4], rq[3] & m_len, rq[2], rq[1], rq[0], 1'b0};
        qualv = setv & ~{4'b0, m_tm, m_wm, 2'b0};
        holdv = {4'b0, m_tm, m_wm, 2'b0};
        m_req  = |qualv;
        m_cold = m_req && (rq[0] || rq[6] || !m_wen);
        if (wr && sel) begin
            m_flags = m_flags & ~(wd[7:0] & ~holdv);
            m_wbi   = wd[8];
        end
        m_flags = m_flags | setv;
        if (wr && !sel) begin
            if (wd[3:0] == 4'h5) m_wm = 1; else if (wd[3:0] == 4'hA) m_wm = 0;
            if (wd[7:4] == 4'h5) m_tm = 1; else if (wd[7:4] == 4'h2) m_tm = 0;
            m_len = wd[8];
            m_wen = wd[9];
        end
        @(negedge clk);
    endtask

    task automatic idle_read(input logic sel);
        reg_wr = 0; reg_sel = sel; reg_wdata = '0;
        {req_secfail, req_jtag, req_sw, req_lockup, req_temp, req_wdog, req_pin} = '0;
        #1;
    endtask

    initial begin
        #(100000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle_read(1);
        chk(reg_rdata, 32'h001, "R1 cause word after reset");
        chk({31'd0, rst_req_o} | {30'd0, rst_cold_o, 1'b0}, 0, "R1 outputs after reset");
        idle_read(0);
        chk(reg_rdata, 32'h22A, "R1 control word after reset");

        // key sweeps from both mask states; other field gets an invalid key
        for (int st = 0; st < 2; st++) begin
            for (int k = 0; k < 16; k++) begin
                cyc(1, 0, {22'd0, 2'b10, 4'h0, (st ? 4'h5 : 4'hA)}, 0);
                cyc(1, 0, {22'd0, 2'b10, 4'h0, 4'(k)}, 0);
                idle_read(0);
                chk(reg_rdata, exp_ctrl(), "R2 R4 watchdog key readback");
                cyc(1, 0, {22'd0, 2'b10, (st ? 4'h5 : 4'h2), 4'h0}, 0);
                cyc(1, 0, {22'd0, 2'b10, 4'(k), 4'h0}, 0);
                idle_read(0);
                chk(reg_rdata, exp_ctrl(), "R3 R4 temperature key readback");
            end
        end

        // full sweep: every configuration against every request pattern
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 128; p++) begin
                cyc(1, 0, {22'd0, c[3], c[2], (c[1] ? 4'h5 : 4'h2), (c[0] ? 4'h5 : 4'hA)}, 0);
                cyc(1, 1, 32'h0FF, 0);
                idle_read(1);
                chk(reg_rdata, {23'd0, m_wbi, m_flags}, "R8 R9 cause word after clear");
                cyc(0, 0, 0, 7'(p));
                chk({31'd0, rst_req_o}, {31'd0, m_req}, "R6 R7 combined request");
                chk({31'd0, rst_cold_o}, {31'd0, m_cold}, "R11 reset class");
                idle_read(1);
                chk(reg_rdata, {23'd0, m_wbi, m_flags}, "R5 R7 cause flags");
            end
        end

        // set wins over clear in the same cycle
        cyc(1, 0, 32'h22A, 0);
        cyc(1, 1, 32'h0FF, 7'b0010000);
        idle_read(1);
        chk(reg_rdata, 32'h020, "R9 set beats clear");

        // warm-boot marker written without touching flags
        cyc(0, 0, 0, 7'b0100001);
        cyc(1, 1, 32'h100, 0);
        idle_read(1);
        chk(reg_rdata, {23'd0, m_wbi, m_flags}, "R10 marker set, flags kept");
        chk(reg_rdata, 32'h162, "R10 marker set value");
        cyc(1, 1, 32'h000, 0);
        idle_read(1);
        chk(reg_rdata, 32'h062, "R10 marker cleared");

        // secure failure with every mask closed and warm enabled
        cyc(1, 0, 32'h255, 0);
        cyc(0, 0, 0, 7'b1000000);
        chk({30'd0, rst_req_o, rst_cold_o}, 32'h3, "R11 secure failure is cold");

        // power-on reset again
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        idle_read(1);
        chk(reg_rdata, 32'h001, "R1 cause word after second reset");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule